// File: doc/BRIEF.md
# Serial-Loaded Octal DAC Register Controller

This block is the digital front end of an eight-channel, 10-bit voltage DAC. A host sends 16-bit command words over a three-wire serial link made of an active-low select/load line, a serial clock and a serial data input. The block runs on its own system clock. It brings the three serial lines into that clock domain through synchronizers and finds their edges there. Each word carries a 4-bit control field and a 10-bit code. When the select line rises, the word is decoded. The decoded command writes one channel register, writes all of them, puts the converter to sleep, or leaves the registers alone.

An active-low clear input zeroes every channel register and ends sleep at once, without waiting for a clock edge. The outgoing end of the shift register drives a serial data output, so several parts can share one data line in a daisy chain. The eight 10-bit codes, a sleep flag and a one-cycle update strobe drive the analog section and any observer.

Top module: `octdac_ctrl`

## Requirements
- R1: After power-on reset, all eight channel codes are zero, and `sleep`, `upd_stb` and `spi_dout` are low.
- R2: Bits shift in MSB first on each rising `spi_sclk` while `spi_cs_n` is low. Clock edges while `spi_cs_n` is high leave the shift register untouched. The word is applied on the rising edge of `spi_cs_n`. In the word, bits 15..12 are the control field, bits 11..2 are the code, and bits 1..0 are ignored.
- R3: Control values 1 through 8 write the code into channel index 0 through 7 respectively. No other channel changes.
- R4: Control value 15 writes the same code into all eight channels.
- R5: Control values 0 and 9 through 13 change no channel register and produce no strobe.
- R6: Control value 14 sets `sleep`, and every channel register keeps its value.
- R7: A completed word with any control value other than 14 clears `sleep`. A no-update word therefore wakes the part with its codes unchanged.
- R8: While `clr_n` is low, all channel codes are zero and `sleep` is low, without any clock edge being needed.
- R9: `spi_dout` takes the shift register's MSB at each falling `spi_sclk` while selected. During a frame it therefore replays the previous 16-bit word, MSB first, ahead of each rising edge.
- R10: A frame longer than 16 bits uses only its last 16 bits.
- R11: `upd_stb` is high for exactly one clock when a single-channel or all-channel write is applied, and stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clr_n | input | 1 | Asynchronous active-low clear of channel codes and sleep |
| spi_cs_n | input | 1 | Active-low select; a rising edge loads the word |
| spi_sclk | input | 1 | Serial clock |
| spi_din | input | 1 | Serial data in, MSB first |
| spi_dout | output | 1 | Serial data out for daisy chaining |
| ch_code | output | 80 | Eight 10-bit channel codes; channel i at bits [10i+9:10i] |
| sleep | output | 1 | Sleep flag |
| upd_stb | output | 1 | One-cycle pulse when a channel write is applied |

## Verification
Every serial input passes two synchronizer stages and one edge-detect register. A command therefore reaches `ch_code`, `sleep` and `upd_stb` on the third rising clock after `spi_cs_n` rises. `spi_dout` likewise moves three clocks after a falling `spi_sclk`. The bench changes inputs on falling clock edges and holds each serial phase for four clocks. It samples `spi_dout` just before the next rising `spi_sclk`. It checks the strobe at the second, third and fourth falling edges after the select rises, so that a pulse that is early, late or too long is caught. The clear is checked one time unit after `clr_n` falls, with no clock edge in between.

// File: rtl/octdac_pkg.sv
package octdac_pkg;
  localparam int unsigned CTRL_W = 4;
  localparam logic [CTRL_W-1:0] CTRL_NONE  = 4'h0;
  localparam logic [CTRL_W-1:0] CTRL_SLEEP = 4'hE;
  localparam logic [CTRL_W-1:0] CTRL_ALL   = 4'hF;

  typedef enum logic [1:0] {OP_NONE, OP_ONE, OP_ALL, OP_SLEEP} op_e;

  function automatic op_e op_of(input logic [CTRL_W-1:0] c, input int unsigned nch);
    if (c == CTRL_ALL) return OP_ALL;
    if (c == CTRL_SLEEP) return OP_SLEEP;
    if (c != CTRL_NONE && 32'(c) <= nch) return OP_ONE;
    return OP_NONE;
  endfunction
endpackage

// File: rtl/octdac_rstsync.sv
module octdac_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] q;
  logic [STAGES-1:0] q_nx;

  always_comb q_nx = {q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= q_nx;
  end

  assign srst_n = q[STAGES-1];
endmodule

// File: rtl/octdac_sync.sv
module octdac_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] nx;
    if (s == 0) begin : g_first
      always_comb nx = d;
    end else begin : g_rest
      always_comb nx = st[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[s] <= RST_VAL;
      else        st[s] <= nx;
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/octdac_shifter.sv
module octdac_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              din_s,
  output logic [WORD_W-1:0] word,
  output logic              frame_end,
  output logic              dout
);
  logic              sclk_q, cs_q, dout_q;
  logic [WORD_W-1:0] shreg, shreg_nx;
  logic              sclk_rise, sclk_fall, shift_en, dout_en, dout_nx;

  always_comb begin
    sclk_rise = sclk_s & ~sclk_q;
    sclk_fall = ~sclk_s & sclk_q;
    shift_en  = sclk_rise & ~cs_n_s;
    dout_en   = sclk_fall & ~cs_n_s;
    frame_end = cs_n_s & ~cs_q;
    shreg_nx  = shift_en ? {shreg[WORD_W-2:0], din_s} : shreg;
    dout_nx   = dout_en ? shreg[WORD_W-1] : dout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      shreg  <= '0;
      dout_q <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_n_s;
      shreg  <= shreg_nx;
      dout_q <= dout_nx;
    end
  end

  assign word = shreg;
  assign dout = dout_q;

  p_dout_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(dout_q));
  p_idle_no_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> $stable(shreg));
endmodule

// File: rtl/octdac_bank.sv
module octdac_bank
  import octdac_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CODE_W = 10,
  parameter int unsigned WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     apply,
  input  logic [WORD_W-1:0]        word,
  output logic [NUM_CH*CODE_W-1:0] ch_flat,
  output logic                     sleep,
  output logic                     upd_stb
);
  logic [CTRL_W-1:0] ctrl;
  logic [CODE_W-1:0] code;
  op_e               op;
  logic [NUM_CH-1:0] wr_en;
  logic              sleep_q, sleep_nx, stb_q, stb_nx;

  always_comb begin
    ctrl = word[WORD_W-1 -: CTRL_W];
    code = word[WORD_W-CTRL_W-1 -: CODE_W];
    op   = op_of(ctrl, NUM_CH);
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [CTRL_W-1:0] MY_CTRL = CTRL_W'(i + 1);
    logic [CODE_W-1:0] q;
    always_comb wr_en[i] = apply & ((op == OP_ALL) | ((op == OP_ONE) & (ctrl == MY_CTRL)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (wr_en[i]) q <= code;
    end
    assign ch_flat[i*CODE_W +: CODE_W] = q;
  end

  always_comb begin
    sleep_nx = apply ? (op == OP_SLEEP) : sleep_q;
    stb_nx   = |wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      sleep_q <= sleep_nx;
      stb_q   <= stb_nx;
    end
  end

  assign sleep   = sleep_q;
  assign upd_stb = stb_q;

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(|wr_en) |=> $stable(ch_flat));
  p_all_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && op == OP_ALL) |=> (ch_flat == {NUM_CH{$past(code)}}));
  p_sleep_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && op == OP_SLEEP) |=> (sleep_q && $stable(ch_flat)));
  p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && op != OP_SLEEP) |=> !sleep_q);
  p_stb_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
  p_stb_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> $past(apply));
endmodule

// File: rtl/octdac_ctrl.sv
module octdac_ctrl #(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned CODE_W      = 10,
  parameter int unsigned PAD_W       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_n,
  input  logic                     spi_cs_n,
  input  logic                     spi_sclk,
  input  logic                     spi_din,
  output logic                     spi_dout,
  output logic [NUM_CH*CODE_W-1:0] ch_code,
  output logic                     sleep,
  output logic                     upd_stb
);
  localparam int unsigned WORD_W = octdac_pkg::CTRL_W + CODE_W + PAD_W;

  logic              core_rst_n, bank_rst_n, clr_arst_n;
  logic [2:0]        ser_s;
  logic [WORD_W-1:0] word;
  logic              apply;

  assign clr_arst_n = rst_n & clr_n;

  octdac_rstsync #(.STAGES(SYNC_STAGES)) u_rst_core (
    .clk(clk), .arst_n(rst_n), .srst_n(core_rst_n));

  octdac_rstsync #(.STAGES(SYNC_STAGES)) u_rst_bank (
    .clk(clk), .arst_n(clr_arst_n), .srst_n(bank_rst_n));

  octdac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(core_rst_n),
    .d({spi_cs_n, spi_sclk, spi_din}), .q(ser_s));

  octdac_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(core_rst_n),
    .sclk_s(ser_s[1]), .cs_n_s(ser_s[2]), .din_s(ser_s[0]),
    .word(word), .frame_end(apply), .dout(spi_dout));

  octdac_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .WORD_W(WORD_W)) u_bank (
    .clk(clk), .rst_n(bank_rst_n), .apply(apply), .word(word),
    .ch_flat(ch_code), .sleep(sleep), .upd_stb(upd_stb));

  p_clear_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    !clr_n |-> (ch_code == '0 && !sleep));
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (ch_code == '0 && !sleep && !upd_stb && !spi_dout));
endmodule

// File: tb/octdac_ctrl_tb.sv
module octdac_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int NCH = 8;
  localparam int CW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0, clr_n = 1'b1, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic dout, sleep, upd_stb;
  logic [NCH*CW-1:0] ch_code;

  int errors = 0;
  int checks = 0;
  logic [CW-1:0] m_ch [NCH];
  logic m_sleep = 1'b0;
  logic [15:0] m_sh = '0;

  always #(CLK_P/2) clk = ~clk;

  octdac_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
    .spi_din(din), .spi_dout(dout), .ch_code(ch_code), .sleep(sleep), .upd_stb(upd_stb));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // 0 = no update, 1 = one channel, 2 = all channels, 3 = sleep
  function automatic int kind_of(input logic [3:0] c);
    if (c == 4'hF) return 2;
    if (c == 4'hE) return 3;
    if (c >= 4'd1 && c <= 4'd8) return 1;
    return 0;
  endfunction

  task automatic check_chans(input string req);
    for (int i = 0; i < NCH; i++)
      chk(req, $sformatf("channel %0d", i), 32'(ch_code[i*CW +: CW]), 32'(m_ch[i]));
    chk(req, "sleep", 32'(sleep), 32'(m_sleep));
  endtask

  task automatic frame(input logic [31:0] bits, input int n, input string req);
    int k;
    logic [3:0] c;
    logic exp_stb;
    cs_n = 1'b0;
    wait_n(4);
    for (int b = n - 1; b >= 0; b--) begin
      din = bits[b];
      wait_n(4);
      chk("R9", "dout before rising sclk", 32'(dout), 32'(m_sh[15]));
      sclk = 1'b1;
      m_sh = {m_sh[14:0], bits[b]};
      wait_n(4);
      sclk = 1'b0;
      wait_n(4);
    end
    cs_n = 1'b1;
    c = m_sh[15:12];
    k = kind_of(c);
    exp_stb = (k == 1) || (k == 2);
    if (k == 1) m_ch[c - 4'd1] = m_sh[11:2];
    if (k == 2) for (int i = 0; i < NCH; i++) m_ch[i] = m_sh[11:2];
    m_sleep = (k == 3);
    wait_n(2);
    chk("R11", "strobe early", 32'(upd_stb), 32'd0);
    wait_n(1);
    chk("R11", "strobe on time", 32'(upd_stb), 32'(exp_stb));
    check_chans(req);
    wait_n(1);
    chk("R11", "strobe width", 32'(upd_stb), 32'd0);
  endtask

  task automatic send(input logic [3:0] c, input logic [9:0] code, input logic [1:0] pad, input string req);
    frame({16'd0, c, code, pad}, 16, req);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL R2 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NCH; i++) m_ch[i] = '0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(5);
    // R1 reset state
    chk("R1", "codes", 32'(ch_code == '0), 32'd1);
    chk("R1", "sleep", 32'(sleep), 32'd0);
    chk("R1", "strobe", 32'(upd_stb), 32'd0);
    chk("R1", "dout", 32'(dout), 32'd0);

    // R3 and R2: each channel, with the padding bits varied
    for (int i = 0; i < NCH; i++)
      send(4'(i + 1), 10'(37 * i + 5), 2'(i), "R3");
    // R4 all channels
    send(4'hF, 10'h2A5, 2'b11, "R4");
    send(4'h3, 10'h3FF, 2'b01, "R3");
    // R5 each no-update code
    send(4'h0, 10'h155, 2'b10, "R5");
    for (int c = 9; c <= 13; c++) send(4'(c), 10'($urandom), 2'b11, "R5");
    // R6 sleep, then R7 wake by a no-update word
    send(4'hE, 10'h001, 2'b00, "R6");
    send(4'hB, 10'h0F0, 2'b00, "R7");
    // R7 wake by a load
    send(4'hE, 10'h000, 2'b00, "R6");
    send(4'h6, 10'h1C3, 2'b00, "R7");
    // R8 asynchronous clear during sleep
    send(4'hE, 10'h000, 2'b00, "R6");
    #1;
    clr_n = 1'b0;
    #1;
    chk("R8", "codes zero", 32'(ch_code == '0), 32'd1);
    chk("R8", "sleep cleared", 32'(sleep), 32'd0);
    for (int i = 0; i < NCH; i++) m_ch[i] = '0;
    m_sleep = 1'b0;
    wait_n(3);
    clr_n = 1'b1;
    wait_n(5);
    check_chans("R8");
    // R10 long frame: four leading bits are dropped
    frame({12'd0, 4'hA, 4'h2, 10'h0C7, 2'b00}, 20, "R10");
    // R2 clock pulses with select high leave the shift register alone
    for (int p = 0; p < 6; p++) begin
      din = p[0];
      wait_n(4);
      sclk = 1'b1;
      wait_n(4);
      sclk = 1'b0;
      wait_n(4);
    end
    send(4'h8, 10'h3A1, 2'b10, "R2");
    // random mix
    for (int r = 0; r < 120; r++) begin
      logic [3:0] c;
      c = 4'($urandom);
      send(c, 10'($urandom), 2'($urandom), "R3");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule